// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block forms the second operand that a data-processing ALU consumes, together with the shifter carry that the flag logic may take as the new C flag. The operand has one of two sources. The first is a 12-bit immediate field, in which an 8-bit constant is rotated right by an even distance. The second is a register value that goes through one of four shift kinds, plus a one-bit rotate through the carry. The register form takes its distance from a 5-bit field in the instruction or from the low byte of a second register. Every distance is handled in one pass of combinational logic.

Decode drives the selects and fields. The incoming C flag comes from flag storage. When the `REG_OUT` parameter is set, the operand and carry are captured into an output register under a clock enable, which gives one cycle of latency. When it is clear, the block is purely combinational.

Top module: `opnd2_shifter`

## Requirements
- R1: With `use_imm`=1, `operand_out` equals `imm_field[7:0]`, zero-extended to 32 bits and rotated right by twice `imm_field[11:8]`. For example, 0xD40 gives 0x00001000 and 0x8FF gives 0x00FF0000.
- R2: With `use_imm`=1, `carry_out` is bit 31 of the result when `imm_field[11:8]` is nonzero, and `c_flag_in` when it is zero.
- R3: `shift_kind` encodes 00 as logical left, 01 as logical right with zero fill, 10 as arithmetic right copying bit 31, and 11 as rotate right. For distances 1 to 31 the result is `rm_val` shifted that way.
- R4: For a nonzero shift, `carry_out` is the last bit moved out of `rm_val`.
- R5: With the 5-bit field as the source (`amt_sel_reg`=0) and `amt_imm`=0, logical left passes `rm_val` and `c_flag_in` through unchanged. Logical right and arithmetic right act as a shift by 32, so the carry is `rm_val[31]`.
- R6: With `amt_sel_reg`=0, `amt_imm`=0 and rotate right selected, the result is `{c_flag_in, rm_val[31:1]}` and `carry_out` is `rm_val[0]`.
- R7: With `amt_sel_reg`=1, only `rs_val[7:0]` sets the distance. A distance of 0 passes `rm_val` and `c_flag_in` through. At exactly 32, logical shifts give 0 with carry `rm_val[0]` (left) or `rm_val[31]` (right). Above 32, logical shifts give 0 with carry 0. At 32 or more, an arithmetic shift gives 32 copies of bit 31, with that bit as the carry.
- R8: With `amt_sel_reg`=1 and rotate right selected, the distance is taken modulo 32. A nonzero multiple of 32 leaves `rm_val` unchanged, with carry `rm_val[31]`.
- R9: With `REG_OUT`=1, the outputs are zero while `rst_n` is low. They show the operand for the inputs present at a rising edge with `cap_en`=1 from that edge on, and they hold their value across edges with `cap_en`=0.
- R10: With `REG_OUT`=0, the outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable for the output register |
| use_imm | input | 1 | 1 selects the rotated immediate, 0 the shifted register |
| imm_field | input | 12 | Rotate count [11:8] and constant [7:0] |
| rm_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | Shift kind, encoded as in R3 |
| amt_sel_reg | input | 1 | 1 takes the distance from `rs_val[7:0]`, 0 from `amt_imm` |
| amt_imm | input | 5 | Distance field taken from the instruction |
| rs_val | input | 32 | Register that supplies the distance in its low byte |
| c_flag_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The bench builds two copies side by side from the same stimulus. One uses `REG_OUT`=1 with the default 32-bit data path and an 8-bit distance byte. The other uses `REG_OUT`=0. With both present, the same-cycle result and the captured, held result are compared against one behavioural model on every cycle. The byte-wide distance reaches the cases at 32, above 32 and at multiples of 32, and a zero 5-bit field reaches the special encodings. With `cap_en` toggling, the hold behaviour of the register is exercised between captures.

// File: rtl/opnd2_pkg.sv
package opnd2_pkg;

  // Shift kind as encoded by decode; the code values are part of the interface.
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  // Operation actually performed after special encodings are resolved.
  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_LSL  = 3'd1,
    OP_LSR  = 3'd2,
    OP_ASR  = 3'd3,
    OP_ROR  = 3'd4,
    OP_RRX  = 3'd5
  } shift_op_e;

endpackage

// File: rtl/opnd2_imm_rot.sv
module opnd2_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  localparam int IMM_FW = IMM_W + ROT_W
) (
  input  logic [IMM_FW-1:0] imm_i,
  input  logic              c_in_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_out_o
);

  localparam int W2 = 2 * DATA_W;

  logic [DATA_W-1:0] const_ext;
  logic [ROT_W:0]    rot_dist;
  logic [W2-1:0]     doubled;

  always_comb begin
    const_ext = DATA_W'(imm_i[IMM_W-1:0]);
    // Rotate distance is the count doubled.
    rot_dist  = {imm_i[IMM_FW-1:IMM_W], 1'b0};
    doubled   = {const_ext, const_ext} >> rot_dist;
    res_o     = doubled[DATA_W-1:0];
    c_out_o   = (imm_i[IMM_FW-1:IMM_W] != '0) ? res_o[DATA_W-1] : c_in_i;
  end

endmodule

// File: rtl/opnd2_amt_decode.sv
module opnd2_amt_decode
  import opnd2_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  shift_kind_e       kind_i,
  input  logic              sel_reg_i,
  input  logic [SH_W-1:0]   amt_imm_i,
  input  logic [AMT_W-1:0]  amt_reg_i,
  output shift_op_e         op_o,
  output logic [SH_W:0]     dist_o,
  output logic              beyond_o
);

  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  function automatic shift_op_e kind_to_op(input shift_kind_e k);
    case (k)
      SK_LSL:  return OP_LSL;
      SK_LSR:  return OP_LSR;
      SK_ASR:  return OP_ASR;
      default: return OP_ROR;
    endcase
  endfunction

  always_comb begin
    op_o     = kind_to_op(kind_i);
    dist_o   = '0;
    beyond_o = 1'b0;
    if (!sel_reg_i) begin
      if (amt_imm_i == '0) begin
        // A zero field carries a special meaning per shift kind.
        unique case (kind_i)
          SK_LSL:  op_o = OP_PASS;
          SK_ROR:  op_o = OP_RRX;
          default: dist_o = (SH_W+1)'(DATA_W);
        endcase
      end else begin
        dist_o = {1'b0, amt_imm_i};
      end
    end else if (amt_reg_i == '0) begin
      op_o = OP_PASS;
    end else if (kind_i == SK_ROR) begin
      dist_o = {1'b0, amt_reg_i[SH_W-1:0]};
    end else if (amt_reg_i >= FULL) begin
      dist_o   = (SH_W+1)'(DATA_W);
      beyond_o = (amt_reg_i != FULL);
    end else begin
      dist_o = (SH_W+1)'(amt_reg_i);
    end
  end

endmodule

// File: rtl/opnd2_shift_core.sv
module opnd2_shift_core
  import opnd2_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  shift_op_e         op_i,
  input  logic [SH_W:0]     dist_i,
  input  logic              beyond_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic              c_in_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_out_o
);

  localparam int W2 = 2 * DATA_W;

  logic [W2-1:0] lsl_w;
  logic [W2-1:0] lsr_w;
  logic [W2-1:0] asr_w;
  logic [W2-1:0] ror_w;

  always_comb begin
    // Extended words keep the last bit shifted out next to the result.
    lsl_w = {{DATA_W{1'b0}}, value_i} << dist_i;
    lsr_w = {value_i, {DATA_W{1'b0}}} >> dist_i;
    asr_w = W2'($signed({value_i, {DATA_W{1'b0}}}) >>> dist_i);
    ror_w = {value_i, value_i} >> dist_i[SH_W-1:0];
  end

  always_comb begin
    res_o   = value_i;
    c_out_o = c_in_i;
    unique case (op_i)
      OP_LSL: begin
        res_o   = lsl_w[DATA_W-1:0];
        c_out_o = beyond_i ? 1'b0 : lsl_w[DATA_W];
      end
      OP_LSR: begin
        res_o   = lsr_w[W2-1:DATA_W];
        c_out_o = beyond_i ? 1'b0 : lsr_w[DATA_W-1];
      end
      OP_ASR: begin
        res_o   = asr_w[W2-1:DATA_W];
        c_out_o = asr_w[DATA_W-1];
      end
      OP_ROR: begin
        res_o   = ror_w[DATA_W-1:0];
        c_out_o = ror_w[DATA_W-1];
      end
      OP_RRX: begin
        res_o   = {c_in_i, value_i[DATA_W-1:1]};
        c_out_o = value_i[0];
      end
      default: begin
        res_o   = value_i;
        c_out_o = c_in_i;
      end
    endcase
  end

endmodule

// File: rtl/opnd2_shifter.sv
module opnd2_shifter
  import opnd2_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int SH_W   = $clog2(DATA_W),
  localparam int IMM_FW = IMM_W + ROT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              use_imm,
  input  logic [IMM_FW-1:0] imm_field,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [1:0]        shift_kind,
  input  logic              amt_sel_reg,
  input  logic [SH_W-1:0]   amt_imm,
  input  logic [DATA_W-1:0] rs_val,
  input  logic              c_flag_in,
  output logic [DATA_W-1:0] operand_out,
  output logic              carry_out
);

  shift_op_e         dec_op;
  logic [SH_W:0]     dec_dist;
  logic              dec_beyond;
  logic [DATA_W-1:0] imm_res;
  logic              imm_c;
  logic [DATA_W-1:0] reg_res;
  logic              reg_c;
  logic [DATA_W-1:0] op_nxt;
  logic              c_nxt;
  logic              unused_rs_hi;

  // Only the low byte of the distance register matters.
  assign unused_rs_hi = ^rs_val[DATA_W-1:AMT_W];

  opnd2_imm_rot #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
  ) u_imm_rot (
    .imm_i   (imm_field),
    .c_in_i  (c_flag_in),
    .res_o   (imm_res),
    .c_out_o (imm_c)
  );

  opnd2_amt_decode #(
    .DATA_W(DATA_W), .AMT_W(AMT_W)
  ) u_amt_dec (
    .kind_i    (shift_kind_e'(shift_kind)),
    .sel_reg_i (amt_sel_reg),
    .amt_imm_i (amt_imm),
    .amt_reg_i (rs_val[AMT_W-1:0]),
    .op_o      (dec_op),
    .dist_o    (dec_dist),
    .beyond_o  (dec_beyond)
  );

  opnd2_shift_core #(
    .DATA_W(DATA_W)
  ) u_core (
    .op_i     (dec_op),
    .dist_i   (dec_dist),
    .beyond_i (dec_beyond),
    .value_i  (rm_val),
    .c_in_i   (c_flag_in),
    .res_o    (reg_res),
    .c_out_o  (reg_c)
  );

  always_comb begin
    op_nxt = use_imm ? imm_res : reg_res;
    c_nxt  = use_imm ? imm_c   : reg_c;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [DATA_W-1:0] op_q, op_d;
      logic              c_q,  c_d;

      always_comb begin
        op_d = cap_en ? op_nxt : op_q;
        c_d  = cap_en ? c_nxt  : c_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          op_q <= '0;
          c_q  <= 1'b0;
        end else begin
          op_q <= op_d;
          c_q  <= c_d;
        end
      end

      assign operand_out = op_q;
      assign carry_out   = c_q;
    end else begin : g_comb
      logic unused_seq;
      assign unused_seq  = clk ^ rst_n ^ cap_en;
      assign operand_out = op_nxt;
      assign carry_out   = c_nxt;
    end
  endgenerate

endmodule

// File: rtl/opnd2_shifter_chk.sv
module opnd2_shifter_chk #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int SH_W   = $clog2(DATA_W),
  localparam int IMM_FW = IMM_W + ROT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_en,
  input logic              use_imm,
  input logic [IMM_FW-1:0] imm_field,
  input logic [DATA_W-1:0] rm_val,
  input logic [1:0]        shift_kind,
  input logic              amt_sel_reg,
  input logic [SH_W-1:0]   amt_imm,
  input logic [DATA_W-1:0] rs_val,
  input logic              c_flag_in,
  input logic [DATA_W-1:0] operand_out,
  input logic              carry_out
);

  // Shadow of the inputs that the current outputs stand for.
  logic              s_valid;
  logic              s_use_imm;
  logic [IMM_FW-1:0] s_imm;
  logic [DATA_W-1:0] s_rm;
  logic [1:0]        s_kind;
  logic              s_sel_reg;
  logic [SH_W-1:0]   s_amt;
  logic [AMT_W-1:0]  s_rs;
  logic              s_c;

  generate
    if (REG_OUT) begin : g_reg_chk
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_valid <= 1'b0; s_use_imm <= 1'b0; s_imm <= '0; s_rm <= '0;
          s_kind <= '0; s_sel_reg <= 1'b0; s_amt <= '0; s_rs <= '0; s_c <= 1'b0;
        end else if (cap_en) begin
          s_valid <= 1'b1; s_use_imm <= use_imm; s_imm <= imm_field; s_rm <= rm_val;
          s_kind <= shift_kind; s_sel_reg <= amt_sel_reg; s_amt <= amt_imm;
          s_rs <= rs_val[AMT_W-1:0]; s_c <= c_flag_in;
        end
      end

      // R9: held across edges without capture
      a_r9_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(operand_out) && $stable(carry_out));

      // R9: cleared while in reset
      always @(posedge clk) begin
        if (!rst_n) a_r9_reset_clear: assert (operand_out == '0 && !carry_out);
      end
    end else begin : g_comb_chk
      always_comb begin
        s_valid = 1'b1; s_use_imm = use_imm; s_imm = imm_field; s_rm = rm_val;
        s_kind = shift_kind; s_sel_reg = amt_sel_reg; s_amt = amt_imm;
        s_rs = rs_val[AMT_W-1:0]; s_c = c_flag_in;
      end
    end
  endgenerate

  // R1: unrotated constant is the zero-extended byte, carry untouched (R2)
  a_r1_plain_constant: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_use_imm && s_imm[IMM_FW-1:IMM_W] == '0
      |-> operand_out == DATA_W'(s_imm[IMM_W-1:0]) && carry_out == s_c);

  // R2: rotated constant carries out its own top bit
  a_r2_rotated_carry: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_use_imm && s_imm[IMM_FW-1:IMM_W] != '0
      |-> carry_out == operand_out[DATA_W-1]);

  // R6: zero rotate field means one-bit rotate through carry
  a_r6_rotate_through_carry: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_use_imm && !s_sel_reg && s_amt == '0 && s_kind == 2'b11
      |-> operand_out == {s_c, s_rm[DATA_W-1:1]} && carry_out == s_rm[0]);

  // R7: zero register distance passes value and carry
  a_r7_zero_distance_pass: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_use_imm && s_sel_reg && s_rs == '0
      |-> operand_out == s_rm && carry_out == s_c);

  // R7: logical shift past the width clears value and carry
  a_r7_logical_beyond: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_use_imm && s_sel_reg && s_rs > AMT_W'(DATA_W) && !s_kind[1]
      |-> operand_out == '0 && !carry_out);

  // R5: zero field with left shift leaves the value alone
  a_r5_left_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_use_imm && !s_sel_reg && s_amt == '0 && s_kind == 2'b00
      |-> operand_out == s_rm && carry_out == s_c);

endmodule

bind opnd2_shifter opnd2_shifter_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .AMT_W(AMT_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/opnd2_shifter_bench.sv
`timescale 1ns/1ps
module opnd2_shifter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_en;
  logic        use_imm;
  logic [11:0] imm_field;
  logic [31:0] rm_val;
  logic [1:0]  shift_kind;
  logic        amt_sel_reg;
  logic [4:0]  amt_imm;
  logic [31:0] rs_val;
  logic        c_flag_in;
  logic [31:0] op_reg, op_comb;
  logic        c_reg, c_comb;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [32:0] exp_reg;
  string       reg_tag;

  always #10 clk = ~clk;

  opnd2_shifter #(.REG_OUT(1'b1)) u_opnd2_shifter (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .use_imm(use_imm),
    .imm_field(imm_field), .rm_val(rm_val), .shift_kind(shift_kind),
    .amt_sel_reg(amt_sel_reg), .amt_imm(amt_imm), .rs_val(rs_val),
    .c_flag_in(c_flag_in), .operand_out(op_reg), .carry_out(c_reg));

  opnd2_shifter #(.REG_OUT(1'b0)) u_opnd2_shifter_comb (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .use_imm(use_imm),
    .imm_field(imm_field), .rm_val(rm_val), .shift_kind(shift_kind),
    .amt_sel_reg(amt_sel_reg), .amt_imm(amt_imm), .rs_val(rs_val),
    .c_flag_in(c_flag_in), .operand_out(op_comb), .carry_out(c_comb));

  // Behavioural model: returns {carry, operand}.
  function automatic logic [32:0] model(input logic ui, input logic [11:0] imm,
      input logic [31:0] rm, input logic [1:0] kind, input logic fr,
      input logic [4:0] a5, input logic [31:0] rs, input logic c);
    logic [31:0] v;
    logic        co;
    int          n;
    v = '0;
    if (ui) begin
      int r;
      r = 2 * int'(imm[11:8]);
      for (int i = 0; i < 32; i++) begin
        int s;
        s = (i + r) % 32;
        v[i] = (s < 8) ? imm[s] : 1'b0;
      end
      co = (imm[11:8] != 0) ? v[31] : c;
      return {co, v};
    end
    n = fr ? int'(rs[7:0]) : int'(a5);
    if (n == 0) begin
      if (fr || kind == 2'd0) return {c, rm};
      if (kind == 2'd3) return {rm[0], c, rm[31:1]};
      n = 32;
    end
    case (kind)
      2'd0: begin
        for (int i = 0; i < 32; i++) v[i] = (i >= n) ? rm[i-n] : 1'b0;
        co = (n <= 32) ? rm[32-n] : 1'b0;
      end
      2'd1: begin
        for (int i = 0; i < 32; i++) v[i] = (i + n < 32) ? rm[i+n] : 1'b0;
        co = (n <= 32) ? rm[n-1] : 1'b0;
      end
      2'd2: begin
        for (int i = 0; i < 32; i++) v[i] = (i + n < 32) ? rm[i+n] : rm[31];
        co = (n <= 32) ? rm[n-1] : rm[31];
      end
      default: begin
        for (int i = 0; i < 32; i++) v[i] = rm[(i + n) % 32];
        co = rm[(n - 1) % 32];
      end
    endcase
    return {co, v};
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual c=%0b op=%08h expected c=%0b op=%08h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  // One cycle: check the registered copy, apply new inputs, check the
  // combinational copy, and note what the register will capture.
  task automatic step(input string req, input logic en, input logic ui,
      input logic [11:0] imm, input logic [31:0] rm, input logic [1:0] kind,
      input logic fr, input logic [4:0] a5, input logic [31:0] rs, input logic c);
    logic [32:0] m;
    @(negedge clk);
    check(reg_tag, {c_reg, op_reg}, exp_reg);
    cap_en = en; use_imm = ui; imm_field = imm; rm_val = rm; shift_kind = kind;
    amt_sel_reg = fr; amt_imm = a5; rs_val = rs; c_flag_in = c;
    #1;
    m = model(ui, imm, rm, kind, fr, a5, rs, c);
    check({req, " R10"}, {c_comb, op_comb}, m);
    if (en) begin
      exp_reg = m;
      reg_tag = {req, " R9"};
    end else begin
      reg_tag = "R9 hold";
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] pat;
    rst_n = 1'b0; cap_en = 1'b0; use_imm = 1'b0; imm_field = '0; rm_val = '0;
    shift_kind = '0; amt_sel_reg = 1'b0; amt_imm = '0; rs_val = '0; c_flag_in = 1'b0;
    exp_reg = '0;
    reg_tag = "R9 reset";
    repeat (3) @(negedge clk);
    // R9: reset state, even with live inputs and enable
    cap_en = 1'b1; rm_val = 32'hFFFF_FFFF; c_flag_in = 1'b1;
    @(negedge clk);
    check("R9 reset", {c_reg, op_reg}, 33'd0);
    cap_en = 1'b0;
    rst_n = 1'b1;

    pat = 32'h8765_4321;
    // R1 / R2: rotated constants
    step("R1", 1, 1, 12'hD40, '0, 0, 0, 0, '0, 1'b1);
    check("R1 0x40 ror 26", {c_comb, op_comb}, {1'b0, 32'h0000_1000});
    step("R1", 1, 1, 12'h8FF, '0, 0, 0, 0, '0, 1'b1);
    check("R1 0xFF ror 16", {c_comb, op_comb}, {1'b0, 32'h00FF_0000});
    step("R2", 1, 1, 12'h1FF, '0, 0, 0, 0, '0, 1'b0);
    check("R2 ror 2 carry", {c_comb, op_comb}, {1'b1, 32'hC000_003F});
    step("R2", 1, 1, 12'h0A5, '0, 0, 0, 0, '0, 1'b1);
    check("R2 no rotate keeps carry", {c_comb, op_comb}, {1'b1, 32'h0000_00A5});
    // R3 / R4: ordinary distances from the 5-bit field
    step("R3", 1, 0, '0, pat, 2'd0, 0, 5'd4, '0, 1'b0);
    check("R3 lsl 4", {c_comb, op_comb}, {1'b0, 32'h7654_3210});
    step("R4", 1, 0, '0, pat, 2'd1, 0, 5'd1, '0, 1'b0);
    check("R4 lsr 1 carry", {c_comb, op_comb}, {1'b1, 32'h43B2_A190});
    step("R3", 1, 0, '0, pat, 2'd2, 0, 5'd8, '0, 1'b0);
    check("R3 asr 8", {c_comb, op_comb}, {1'b0, 32'hFF87_6543});
    step("R3", 1, 0, '0, pat, 2'd3, 0, 5'd31, '0, 1'b0);
    step("R4", 1, 0, '0, pat, 2'd0, 0, 5'd31, '0, 1'b0);
    // R5 / R6: zero field encodings
    step("R5", 1, 0, '0, pat, 2'd0, 0, 5'd0, '0, 1'b1);
    step("R5", 1, 0, '0, pat, 2'd1, 0, 5'd0, '0, 1'b0);
    check("R5 lsr 32", {c_comb, op_comb}, {1'b1, 32'h0});
    step("R5", 1, 0, '0, pat, 2'd2, 0, 5'd0, '0, 1'b0);
    check("R5 asr 32", {c_comb, op_comb}, {1'b1, 32'hFFFF_FFFF});
    step("R6", 1, 0, '0, pat, 2'd3, 0, 5'd0, '0, 1'b0);
    check("R6 rrx", {c_comb, op_comb}, {1'b1, 32'h43B2_A190});
    // R7 / R8: register-supplied distances
    step("R7", 1, 0, '0, pat, 2'd1, 1, 5'd3, 32'hFFFF_FF00, 1'b1);
    check("R7 low byte zero", {c_comb, op_comb}, {1'b1, pat});
    step("R7", 1, 0, '0, pat, 2'd0, 1, 0, 32'd32, 1'b0);
    check("R7 lsl 32", {c_comb, op_comb}, {1'b1, 32'h0});
    step("R7", 1, 0, '0, pat, 2'd1, 1, 0, 32'd33, 1'b1);
    check("R7 lsr 33", {c_comb, op_comb}, {1'b0, 32'h0});
    step("R7", 1, 0, '0, pat, 2'd0, 1, 0, 32'd255, 1'b1);
    step("R7", 1, 0, '0, 32'h7000_0001, 2'd2, 1, 0, 32'd200, 1'b1);
    check("R7 asr 200", {c_comb, op_comb}, {1'b0, 32'h0});
    step("R8", 1, 0, '0, pat, 2'd3, 1, 0, 32'd64, 1'b0);
    check("R8 ror 64", {c_comb, op_comb}, {1'b1, pat});
    step("R8", 1, 0, '0, pat, 2'd3, 1, 0, 32'd36, 1'b0);
    check("R8 ror 36", {c_comb, op_comb}, {1'b0, 32'h1876_5432});
    // R9: hold with enable low, then capture again
    step("R9", 0, 1, 12'h0FF, '0, 0, 0, 0, '0, 1'b1);
    step("R9", 0, 0, '0, 32'hFFFF_FFFF, 2'd1, 0, 5'd2, '0, 1'b0);
    step("R9", 1, 1, 12'h3C3, '0, 0, 0, 0, '0, 1'b0);
    // Mixed patterns across all modes
    for (int k = 0; k < 600; k++) begin
      logic [31:0] rs_r;
      rs_r = $urandom;
      if (k % 3 == 0) rs_r[7:0] = 8'($urandom_range(0, 40));
      step("R3 R4 R7 random", ($urandom % 4) != 0, ($urandom % 4) == 0,
           12'($urandom), $urandom, 2'($urandom), 1'($urandom),
           (k % 7 == 0) ? 5'd0 : 5'($urandom), rs_r, 1'($urandom));
    end
    step("R9", 0, 0, '0, '0, 0, 0, 0, '0, 1'b0);
    @(negedge clk);
    check(reg_tag, {c_reg, op_reg}, exp_reg);
    done = 1'b1;
    finish_run();
  end

endmodule